// File: doc/BRIEF.md
# I2C Page-Buffered Memory Write Target

This block is the write side of a serial nonvolatile memory that sits on an I2C bus as a target. It watches the SCL and SDA lines, which are synchronised into a system clock domain. It recognises bus START and STOP conditions and takes in a transaction made of three parts: an addressing byte, a two-byte word address, and a run of data bytes. SDA is open-drain. The block drives the line low only through `sda_oe` to acknowledge a byte.

Incoming data bytes are collected in a 32-entry page buffer that marks each entry it fills. Nothing reaches the 4096-byte array until the master ends the transaction with STOP. At that point a timed internal write cycle starts, `busy` is raised, and the marked entries are copied into the page the pointer selects. While that cycle runs, the block refuses to acknowledge its own address, so the master can poll for completion. A synchronous read port lets the surrounding logic see the array contents.

Top module: `i2c_page_wr_target`

## Requirements
- R1: The first byte after START is acknowledged only if it equals {4'b1010, sel[2:0], 1'b0}, with bit 7 first and bit 0 the read/write flag. The acknowledge is `sda_oe`=1 during the ninth SCL clock, and `sda_oe` changes only while SCL is low. Any other first byte is not acknowledged. The bytes that follow it in that transaction are then neither acknowledged nor written.
- R2: Both word-address bytes are acknowledged. Bits 3:0 of the first address byte become address bits 11:8, and its bits 7:4 are ignored. The second address byte supplies address bits 7:0.
- R3: Each data byte is acknowledged. After STOP, the byte can be read from the array at its address through the read port: `mem_rdata` shows the contents at `mem_raddr` one clock later. A committed transaction produces exactly one internal write cycle.
- R4: After each data byte only address bits 4:0 increment, so a run of bytes wraps from offset 31 to offset 0 of the same 32-byte page.
- R5: When more than 32 data bytes arrive before STOP, each later byte replaces the earlier byte that landed on the same page offset.
- R6: The array does not change before STOP. A commit changes only the page offsets written in that transaction.
- R7: `busy` stays high for exactly WR_CYCLES system clocks for each committed transaction.
- R8: While `busy` is high, a control byte that would otherwise match is not acknowledged, and its transaction writes nothing.
- R9: In the following cases no write cycle starts and the array is unchanged: a START or STOP after two or more bits of a byte have been sampled, a STOP before any data byte, or a repeated START. Data bytes sent before a repeated START are discarded.
- R10: During and right after reset, `sda_oe` and `busy` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Sensed level of the bus data line |
| sda_oe | output | 1 | 1 pulls the data line low (acknowledge) |
| sel | input | 3 | Device select straps compared with the control byte |
| busy | output | 1 | Internal write cycle in progress |
| mem_raddr | input | ADDR_W | Array read address |
| mem_rdata | output | 8 | Array read data, one clock after the address |

## Verification
The bench goes after the page-edge cases.

- **Run that crosses offset 31.** A design that carried the increment into bit 5 would write into the next page.
- **Run longer than 32 bytes.** A design that stopped at 32 entries would keep the first bytes instead of the last.
- **Short write into a page already filled.** A design that copied all 32 buffer entries would overwrite untouched offsets with stale data.
- **Bus aborts.** The bench sends a repeated START after data bytes, a STOP partway through a byte, and a STOP right after the address. A design that committed on any of these would raise `busy` and corrupt the page.
- **Control byte during a write cycle.** The bench sends one while `busy` is high. A design that acknowledged it would lose the master's polling signal.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  // Receiver phase within a transaction
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RECV,
    PH_ACK,
    PH_SKIP
  } phase_t;

  // Which byte of the transaction is being shifted in
  typedef enum logic [1:0] {
    BY_CTRL,
    BY_AHI,
    BY_ALO,
    BY_DATA
  } byte_t;

  localparam logic [3:0] CTRL_CODE = 4'b1010;
endpackage

// File: rtl/pgw_sync.sv
// Brings SCL/SDA into the system clock domain and flags bus events.
module pgw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_p;
  logic [STAGES-1:0] sda_p;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p <= {scl_p[STAGES-2:0], scl};
      sda_p <= {sda_p[STAGES-2:0], sda};
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_s     = scl_p[STAGES-1];
  assign sda_s     = sda_p[STAGES-1];
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
endmodule

// File: rtl/pgw_ctl.sv
// Bit/byte receiver: shifts bytes, decides acknowledge, emits byte events.
module pgw_ctl
  import pgw_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic [2:0] sel,
  input  logic       busy,
  output logic       sda_oe,
  output logic       ev_hi,
  output logic       ev_lo,
  output logic       ev_data,
  output logic [7:0] ev_byte,
  output logic       commit,
  output logic       clear
);
  phase_t     phase;
  byte_t      which;
  logic [3:0] bitcnt;
  logic [7:0] shreg;
  logic       have_data;
  logic       ctrl_ok;

  assign ctrl_ok = (shreg[7:4] == CTRL_CODE) && (shreg[3:1] == sel) &&
                   !shreg[0] && !busy;
  assign ev_byte = shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      which     <= BY_CTRL;
      bitcnt    <= '0;
      shreg     <= '0;
      have_data <= 1'b0;
      sda_oe    <= 1'b0;
      ev_hi     <= 1'b0;
      ev_lo     <= 1'b0;
      ev_data   <= 1'b0;
      commit    <= 1'b0;
      clear     <= 1'b0;
    end else begin
      ev_hi   <= 1'b0;
      ev_lo   <= 1'b0;
      ev_data <= 1'b0;
      commit  <= 1'b0;
      clear   <= 1'b0;
      if (start_det) begin
        // new or repeated START: drop anything gathered so far
        phase     <= PH_RECV;
        which     <= BY_CTRL;
        bitcnt    <= '0;
        sda_oe    <= 1'b0;
        have_data <= 1'b0;
        clear     <= 1'b1;
      end else if (stop_det) begin
        // STOP counts only on a byte boundary (at most the first bit sampled)
        commit    <= (phase == PH_RECV) && (which == BY_DATA) && have_data &&
                     (bitcnt <= 4'd1);
        phase     <= PH_IDLE;
        sda_oe    <= 1'b0;
        have_data <= 1'b0;
      end else begin
        case (phase)
          PH_RECV: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              if (which != BY_CTRL || ctrl_ok) begin
                sda_oe <= 1'b1;
                phase  <= PH_ACK;
                case (which)
                  BY_CTRL: which <= BY_AHI;
                  BY_AHI: begin
                    which <= BY_ALO;
                    ev_hi <= 1'b1;
                  end
                  BY_ALO: begin
                    which <= BY_DATA;
                    ev_lo <= 1'b1;
                  end
                  BY_DATA: begin
                    ev_data   <= 1'b1;
                    have_data <= 1'b1;
                  end
                endcase
              end else begin
                phase <= PH_SKIP;
              end
            end
          end
          PH_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              phase  <= PH_RECV;
              bitcnt <= '0;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/pgw_page.sv
// Address pointer, page buffer with per-entry marks, and the timed commit.
// WR_CYCLES must exceed the page size so every entry is copied while busy.
module pgw_page #(
  parameter int ADDR_W    = 12,
  parameter int PAGE_W    = 5,
  parameter int WR_CYCLES = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ev_hi,
  input  logic              ev_lo,
  input  logic              ev_data,
  input  logic [7:0]        ev_byte,
  input  logic              commit,
  input  logic              clear,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);
  localparam int PAGE_N = 1 << PAGE_W;
  localparam int HI_W   = ADDR_W - 8;
  localparam int TAG_W  = ADDR_W - PAGE_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] T_LAST = CNT_W'(WR_CYCLES - 1);
  localparam logic [CNT_W-1:0] T_COPY = CNT_W'(PAGE_N);

  logic [ADDR_W-1:0] ptr;
  logic [TAG_W-1:0]  tag;
  logic [CNT_W-1:0]  tmr;
  logic [PAGE_N-1:0] valid;
  logic [7:0]        pbuf [PAGE_N];
  logic [PAGE_W-1:0] wr_idx;
  logic [PAGE_W-1:0] rd_idx;

  assign wr_idx = ptr[PAGE_W-1:0];
  assign rd_idx = tmr[PAGE_W-1:0];

  always_ff @(posedge clk) begin
    if (ev_data) pbuf[wr_idx] <= ev_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      tag       <= '0;
      tmr       <= '0;
      valid     <= '0;
      busy      <= 1'b0;
      mem_we    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      mem_we <= 1'b0;
      if (ev_hi) ptr[ADDR_W-1:8] <= ev_byte[HI_W-1:0];
      if (ev_lo) ptr[7:0] <= ev_byte;
      if (ev_data) begin
        valid[wr_idx]      <= 1'b1;
        ptr[PAGE_W-1:0]    <= wr_idx + 1'b1;   // page-local wrap
      end
      if (clear && !busy) valid <= '0;
      if (commit) begin
        busy <= 1'b1;
        tmr  <= '0;
        tag  <= ptr[ADDR_W-1:PAGE_W];
      end else if (busy) begin
        tmr <= tmr + 1'b1;
        if (tmr < T_COPY) begin
          mem_we    <= valid[rd_idx];
          mem_waddr <= {tag, rd_idx};
          mem_wdata <= pbuf[rd_idx];
        end
        if (tmr == T_LAST) begin
          busy  <= 1'b0;
          valid <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/pgw_mem.sv
// Byte array, one write port and one registered read port.
module pgw_mem #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/i2c_page_wr_target.sv
module i2c_page_wr_target #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int WR_CYCLES   = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl,
  input  logic              sda_in,
  output logic              sda_oe,
  input  logic [2:0]        sel,
  output logic              busy,
  input  logic [ADDR_W-1:0] mem_raddr,
  output logic [7:0]        mem_rdata
);
  logic              scl_s;
  logic              sda_s;
  logic              start_det;
  logic              stop_det;
  logic              scl_rise;
  logic              scl_fall;
  logic              ev_hi;
  logic              ev_lo;
  logic              ev_data;
  logic [7:0]        ev_byte;
  logic              commit;
  logic              clear;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;

  pgw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl(scl), .sda(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  pgw_ctl u_ctl (
    .clk(clk), .rst(rst), .start_det(start_det), .stop_det(stop_det),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s), .sel(sel),
    .busy(busy), .sda_oe(sda_oe), .ev_hi(ev_hi), .ev_lo(ev_lo),
    .ev_data(ev_data), .ev_byte(ev_byte), .commit(commit), .clear(clear)
  );

  pgw_page #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WR_CYCLES(WR_CYCLES)) u_page (
    .clk(clk), .rst(rst), .ev_hi(ev_hi), .ev_lo(ev_lo), .ev_data(ev_data),
    .ev_byte(ev_byte), .commit(commit), .clear(clear), .busy(busy),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  pgw_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );
endmodule

// File: rtl/pgw_checker.sv
module pgw_checker #(
  parameter int WR_CYCLES = 48
) (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic sda_oe,
  input logic busy,
  input logic stop_det,
  input logic mem_we
);
  logic [31:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 32'd1;
    else           run_len <= '0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!sda_oe && !busy)); // R10
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s); // R1
  AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe); // R8
  AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_det, 2)); // R6
  AST_WRITE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy); // R6
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == 32'(WR_CYCLES))); // R7
endmodule

bind i2c_page_wr_target pgw_checker #(.WR_CYCLES(WR_CYCLES)) u_pgw_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .busy(busy),
  .stop_det(stop_det), .mem_we(mem_we)
);

// File: tb/i2c_page_wr_target_bench.sv
module i2c_page_wr_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WRC        = 400;
  localparam int Q          = 5;
  localparam int WATCHDOG   = 190000;
  localparam logic [2:0] MY_SEL = 3'b101;
  localparam logic [7:0] CW     = {4'b1010, MY_SEL, 1'b0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [2:0]  sel = MY_SEL;
  logic [11:0] mem_raddr = '0;
  logic        sda_oe;
  logic        busy;
  logic [7:0]  mem_rdata;
  logic        sda_bus;

  assign sda_bus = sda_m & ~sda_oe;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_page_wr_target #(.WR_CYCLES(WRC)) u_i2c_page_wr_target (
    .clk(clk), .rst(rst), .scl(scl), .sda_in(sda_bus), .sda_oe(sda_oe),
    .sel(sel), .busy(busy), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
  );

  int         checks = 0;
  int         errors = 0;
  logic [7:0] model [4096];
  logic       known [4096];
  logic [7:0] dbuf  [64];
  int         busy_rises = 0;
  int         busy_len = 0;
  int         busy_run = 0;
  logic       busy_d = 1'b0;

  always @(negedge clk) begin
    if (busy) busy_run++;
    else if (busy_run != 0) begin
      busy_len = busy_run;
      busy_run = 0;
    end
    if (busy && !busy_d) busy_rises++;
    busy_d = busy;
  end

  task automatic ticks(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_ctrl_ack(logic [7:0] c, logic bsy);
    return (c[7:4] == 4'b1010) && (c[3:1] == MY_SEL) && !c[0] && !bsy;
  endfunction

  function automatic logic [11:0] slot(logic [11:0] base, int i);
    return {base[11:5], 5'(base[4:0] + i)};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; ticks(Q);
    scl = 1'b1;   ticks(Q);
    sda_m = 1'b0; ticks(Q);
    scl = 1'b0;   ticks(Q);
  endtask

  task automatic bus_stop();
    scl = 1'b0; sda_m = 1'b0; ticks(Q);
    scl = 1'b1;   ticks(Q);
    sda_m = 1'b1; ticks(2*Q);
  endtask

  task automatic bus_bits(logic [7:0] b, int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; ticks(Q);
      scl = 1'b1;   ticks(2*Q);
      scl = 1'b0;   ticks(Q);
    end
  endtask

  task automatic bus_byte(logic [7:0] b, output logic ack);
    bus_bits(b, 8);
    sda_m = 1'b1; ticks(Q);
    scl = 1'b1;   ticks(Q);
    ack = ~sda_bus;
    ticks(Q);
    scl = 1'b0;   ticks(Q);
  endtask

  // START, control, two address bytes, n data bytes from dbuf; no STOP
  task automatic send_write(logic [7:0] ctrl, logic [7:0] hi, logic [7:0] lo,
                            int n, string req);
    logic ack;
    logic exp;
    exp = exp_ctrl_ack(ctrl, busy);
    bus_start();
    bus_byte(ctrl, ack); chk(req, "control ack", int'(ack), int'(exp));
    bus_byte(hi, ack);   chk(exp ? "R2" : req, "high address ack", int'(ack), int'(exp));
    bus_byte(lo, ack);   chk(exp ? "R2" : req, "low address ack", int'(ack), int'(exp));
    for (int i = 0; i < n; i++) begin
      bus_byte(dbuf[i], ack);
      chk(exp ? "R3" : req, "data ack", int'(ack), int'(exp));
    end
  endtask

  task automatic finish_write(int rises0);
    while (busy) ticks(1);
    ticks(2);
    chk("R7", "busy length", busy_len, WRC);
    chk("R3", "write cycles started", busy_rises, rises0 + 1);
  endtask

  task automatic no_write(int rises0, string req);
    ticks(30);
    chk(req, "no write cycle", busy_rises, rises0);
    chk(req, "busy idle", int'(busy), 0);
  endtask

  task automatic model_apply(logic [11:0] base, int n);
    for (int i = 0; i < n; i++) begin
      model[slot(base, i)] = dbuf[i];
      known[slot(base, i)] = 1'b1;
    end
  endtask

  task automatic read_mem(logic [11:0] a, output logic [7:0] d);
    mem_raddr = a;
    ticks(1);
    d = mem_rdata;
  endtask

  task automatic check_page(logic [11:0] base, string req);
    logic [7:0]  d;
    logic [11:0] a;
    for (int i = 0; i < 32; i++) begin
      a = {base[11:5], 5'(i)};
      if (known[a]) begin
        read_mem(a, d);
        chk(req, $sformatf("mem[%0h]", a), int'(d), int'(model[a]));
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(negedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int          r0;
    logic [7:0]  d;
    logic [11:0] base;
    logic [7:0]  ctrl;
    int          n;
    logic        bad;
    for (int i = 0; i < 4096; i++) begin
      known[i] = 1'b0;
      model[i] = '0;
    end
    r0 = int'($urandom(32'd7351));

    // R10: reset state
    ticks(4);
    chk("R10", "sda_oe in reset", int'(sda_oe), 0);
    chk("R10", "busy in reset", int'(busy), 0);
    rst = 1'b0;
    ticks(5);
    chk("R10", "sda_oe after reset", int'(sda_oe), 0);
    chk("R10", "busy after reset", int'(busy), 0);

    // R4: fill one whole page
    for (int i = 0; i < 32; i++) dbuf[i] = 8'h40 + 8'(i);
    r0 = busy_rises;
    send_write(CW, 8'h03, 8'hE0, 32, "R1");
    bus_stop();
    finish_write(r0);
    model_apply(12'h3E0, 32);
    check_page(12'h3E0, "R4");

    // R2 + R6: single byte, high nibble of address byte set, before/after STOP
    dbuf[0] = 8'h5A;
    r0 = busy_rises;
    send_write(CW, 8'hF3, 8'hE7, 1, "R1");
    read_mem(12'h3E7, d);
    chk("R6", "array before STOP", int'(d), int'(model[12'h3E7]));
    bus_stop();
    finish_write(r0);
    model_apply(12'h3E7, 1);
    read_mem(12'h3E7, d);
    chk("R2", "byte at 3E7", int'(d), 32'h5A);
    check_page(12'h3E0, "R6");

    // R4: run crossing offset 31
    for (int i = 0; i < 6; i++) dbuf[i] = 8'h90 + 8'(i);
    r0 = busy_rises;
    send_write(CW, 8'h03, 8'hFC, 6, "R1");
    bus_stop();
    finish_write(r0);
    model_apply(12'h3FC, 6);
    read_mem(12'h3E1, d);
    chk("R4", "wrapped byte at 3E1", int'(d), 32'h95);
    check_page(12'h3E0, "R4");

    // R5: 35 bytes overwrite the first three offsets
    for (int i = 0; i < 35; i++) dbuf[i] = 8'hC0 + 8'(i);
    r0 = busy_rises;
    send_write(CW, 8'h03, 8'hE0, 35, "R1");
    bus_stop();
    finish_write(r0);
    model_apply(12'h3E0, 35);
    read_mem(12'h3E0, d);
    chk("R5", "overwritten byte at 3E0", int'(d), 32'hE0);
    check_page(12'h3E0, "R5");

    // R1: wrong select, wrong code, read flag
    for (int k = 0; k < 3; k++) begin
      ctrl = (k == 0) ? 8'hA6 : (k == 1) ? 8'h2A : 8'hAB;
      dbuf[0] = 8'hFF; dbuf[1] = 8'hFF;
      r0 = busy_rises;
      send_write(ctrl, 8'h03, 8'hE0, 2, "R1");
      bus_stop();
      no_write(r0, "R1");
      check_page(12'h3E0, "R1");
    end

    // R8: control byte while the write cycle runs
    dbuf[0] = 8'h3C;
    r0 = busy_rises;
    send_write(CW, 8'h05, 8'h01, 1, "R1");
    bus_stop();
    dbuf[0] = 8'hA5;
    send_write(CW, 8'h05, 8'h01, 1, "R8");
    bus_stop();
    finish_write(r0);
    dbuf[0] = 8'h3C;
    model_apply(12'h501, 1);
    check_page(12'h500, "R8");

    // R9: STOP right after the address
    r0 = busy_rises;
    send_write(CW, 8'h03, 8'hE4, 0, "R1");
    bus_stop();
    no_write(r0, "R9");

    // R9: STOP after four bits of a data byte
    dbuf[0] = 8'h01;
    r0 = busy_rises;
    send_write(CW, 8'h03, 8'hE2, 1, "R1");
    bus_bits(8'h77, 4);
    bus_stop();
    no_write(r0, "R9");
    check_page(12'h3E0, "R9");

    // R9: repeated START discards earlier data bytes
    dbuf[0] = 8'h11; dbuf[1] = 8'h22;
    r0 = busy_rises;
    send_write(CW, 8'h03, 8'hE0, 2, "R1");
    dbuf[0] = 8'h33;
    send_write(CW, 8'h03, 8'hE5, 1, "R1");
    bus_stop();
    finish_write(r0);
    model_apply(12'h3E5, 1);
    check_page(12'h3E0, "R9");

    // Randomised page writes, some to a foreign select code
    for (int k = 0; k < 8; k++) begin
      base = 12'($urandom);
      n    = 1 + int'($urandom % 40);
      bad  = ($urandom % 5) == 0;
      ctrl = bad ? 8'hA6 : CW;
      for (int i = 0; i < n; i++) dbuf[i] = 8'($urandom);
      r0 = busy_rises;
      send_write(ctrl, {4'($urandom), base[11:8]}, base[7:0], n, "R1");
      bus_stop();
      if (bad) no_write(r0, "R1");
      else begin
        finish_write(r0);
        model_apply(base, n);
      end
      check_page(base, "R4");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule